// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block serialises one data word at a time onto an asynchronous serial line. The frame format is chosen at run time: data length from 4 to 16 bits, optional even or odd parity, a stop period of half, one, one-and-a-half or two bit times, and 16, 8, 6 or 4 oversample ticks per bit. All bit timing is counted in ticks of an oversample strobe that arrives from outside. Because of this, fractional stop periods come out exact to the tick.

A word is offered with a valid/ready handshake together with its own break flag. The format inputs are captured at the moment the word is taken, so software may prepare the next format while a frame is still on the line. On the pin side, the block can invert the line and can release the driver while nothing is being sent. It can send the word most significant bit first. A word flagged as a break holds the line at its active-low level for the whole frame length, and the line then rests high for one bit time before the next word is taken.

Top module: `sframe_tx`

## Requirements
- R1: Data-length code `len_code` values 1 to 13 give 3 more data bits than the code (4 to 16). Code 0 is treated as 4 bits and codes 14 and 15 as 16 bits.
- R2: Before inversion, a frame is a low start bit, then the data bits, then the parity bit if enabled, then a high stop period. Every bit other than the stop period lasts exactly one bit time of ticks.
- R3: Oversample code `ovs_code` 0, 1, 2 and 3 gives a bit time of 16, 8, 6 and 4 ticks.
- R4: Parity code `par_code` values 0 and 1 send no parity bit. Code 2 sends even parity, so the data ones plus the parity bit are even. Code 3 sends odd parity. Parity covers only the data bits of the selected length.
- R5: Stop code `stop_code` 0, 1, 2 and 3 gives a stop period of H, B, B+H and 2B ticks, where B is the bit time and H is B/2 rounded down.
- R6: Data goes out least significant bit first when `msb_first` is 0, and from bit length-1 down to bit 0 when it is 1.
- R7: `tx_out` is the line level XOR `cfg_invert` at all times, including idle, where the line level is high.
- R8: `tx_oe` is low exactly while the transmitter is idle and `cfg_auto_tri` is 1. It is high during every frame and break.
- R9: A word taken with `in_break` set drives the line low for the start, data, parity and stop time of its format. The line then stays high for one bit time, and only after that does `in_ready` return.
- R10: `in_ready` is high only while the transmitter is idle, and a word is taken on a clock edge where `in_valid` and `in_ready` are both high. `tx_done` is a single-cycle pulse in the cycle after the tick that ends the stop period.
- R11: Format inputs that change while a frame is in flight do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample strobe, one cycle per tick |
| len_code | input | 4 | Data-length code |
| par_code | input | 2 | Parity code |
| stop_code | input | 2 | Stop-period code |
| ovs_code | input | 2 | Ticks-per-bit code |
| msb_first | input | 1 | Send most significant data bit first |
| cfg_invert | input | 1 | Invert the line at the pin |
| cfg_auto_tri | input | 1 | Release the line while idle |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken (idle) |
| in_data | input | 16 | Data word, right-aligned |
| in_break | input | 1 | Send this word as a break |
| tx_out | output | 1 | Serial line value |
| tx_oe | output | 1 | Line driver enable |
| tx_done | output | 1 | End-of-stop pulse |

## Verification
The end-of-stop pulse and the taking of the next word can fall in the same cycle: the block is idle again in the cycle that carries `tx_done`. The bench provokes this by offering each new word while the previous frame is still running. It then judges the result at the tick level, which shows the new start bit with no extra idle tick, and by requiring that no expected samples of the finished frame remain when `tx_done` appears. After a break, the same check instead requires that exactly one bit time of high samples is still pending, and that the handshake stays closed until they have gone out.

// File: rtl/sftx_pkg.sv
`timescale 1ns/1ps
package sftx_pkg;
  localparam int DMAX = 16;
  localparam int NBW  = $clog2(DMAX + 1);
  localparam int IW   = $clog2(DMAX);
  localparam int TW   = $clog2(2 * 16 + 1);

  typedef enum logic [2:0] {
    SEG_IDLE, SEG_START, SEG_DATA, SEG_PAR, SEG_STOP, SEG_GAP
  } seg_e;

  function automatic logic [NBW-1:0] width_of(input logic [3:0] code);
    if (code == 4'd0) return NBW'(4);
    if (code > 4'd13) return NBW'(16);
    return NBW'(code) + NBW'(3);
  endfunction

  function automatic logic [TW-1:0] ticks_per_bit(input logic [1:0] code);
    case (code)
      2'd0:    return TW'(16);
      2'd1:    return TW'(8);
      2'd2:    return TW'(6);
      default: return TW'(4);
    endcase
  endfunction

  function automatic logic [TW-1:0] stop_span(input logic [1:0] stop, input logic [1:0] ovs);
    logic [TW-1:0] full, half;
    full = ticks_per_bit(ovs);
    half = full >> 1;
    case (stop)
      2'd0:    return half;
      2'd1:    return full;
      2'd2:    return full + half;
      default: return full + full;
    endcase
  endfunction

  function automatic logic [DMAX-1:0] low_mask(input logic [NBW-1:0] n);
    logic [DMAX-1:0] m;
    for (int i = 0; i < DMAX; i++) m[i] = (NBW'(i) < n);
    return m;
  endfunction

  function automatic logic [DMAX-1:0] order_bits(input logic [DMAX-1:0] d,
                                                 input logic [NBW-1:0] n,
                                                 input logic msb);
    logic [DMAX-1:0] r;
    logic [NBW-1:0]  k;
    r = '0;
    for (int i = 0; i < DMAX; i++) begin
      k = n - NBW'(1) - NBW'(i);
      if (NBW'(i) < n) r[i] = msb ? d[k[IW-1:0]] : d[i];
    end
    return r;
  endfunction

  function automatic logic parity_of(input logic [DMAX-1:0] d,
                                     input logic [NBW-1:0] n,
                                     input logic odd);
    return (^(d & low_mask(n))) ^ odd;
  endfunction
endpackage

// File: rtl/sftx_shaper.sv
`timescale 1ns/1ps
module sftx_shaper
  import sftx_pkg::*;
(
  input  logic [DMAX-1:0] in_data,
  input  logic [3:0]      len_code,
  input  logic [1:0]      par_code,
  input  logic            msb_first,
  output logic [DMAX-1:0] word,
  output logic [NBW-1:0]  nbits,
  output logic            par_en,
  output logic            par_val
);
  always_comb begin
    nbits   = width_of(len_code);
    word    = order_bits(in_data, nbits, msb_first);
    par_en  = par_code[1];
    par_val = parity_of(in_data, nbits, par_code[0]);
  end
endmodule

// File: rtl/sftx_seq.sv
`timescale 1ns/1ps
module sftx_seq
  import sftx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            load,
  input  logic [DMAX-1:0] ld_word,
  input  logic [NBW-1:0]  ld_nbits,
  input  logic            ld_par_en,
  input  logic            ld_par_val,
  input  logic            ld_brk,
  input  logic [TW-1:0]   ld_olim,
  input  logic [TW-1:0]   ld_slim,
  output logic            level,
  output logic            idle,
  output logic            done,
  output logic            bit_step,
  output logic            brk_q
);
  seg_e            seg;
  logic [TW-1:0]   tcnt, olim, slim, lim;
  logic [NBW-1:0]  bidx, nb;
  logic [DMAX-1:0] sh;
  logic            pe, pv;

  assign idle     = (seg == SEG_IDLE);
  assign lim      = (seg == SEG_STOP) ? slim : olim;
  assign bit_step = tick && !idle && (tcnt == lim - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_IDLE; tcnt <= '0; bidx <= '0; nb <= '0; sh <= '0;
      pe <= 1'b0; pv <= 1'b0; brk_q <= 1'b0; olim <= '0; slim <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        seg <= SEG_START; tcnt <= '0; bidx <= '0;
        sh <= ld_word; nb <= ld_nbits; pe <= ld_par_en; pv <= ld_par_val;
        brk_q <= ld_brk; olim <= ld_olim; slim <= ld_slim;
      end else if (bit_step) begin
        tcnt <= '0;
        case (seg)
          SEG_START: seg <= SEG_DATA;
          SEG_DATA: begin
            if (bidx == nb - NBW'(1)) seg <= pe ? SEG_PAR : SEG_STOP;
            else begin
              bidx <= bidx + NBW'(1);
              sh   <= sh >> 1;
            end
          end
          SEG_PAR:  seg <= SEG_STOP;
          SEG_STOP: begin
            seg  <= brk_q ? SEG_GAP : SEG_IDLE;
            done <= 1'b1;
          end
          default:  seg <= SEG_IDLE;
        endcase
      end else if (tick && !idle) begin
        tcnt <= tcnt + TW'(1);
      end
    end
  end

  always_comb begin
    case (seg)
      SEG_START: level = 1'b0;
      SEG_DATA:  level = sh[0];
      SEG_PAR:   level = pv;
      default:   level = 1'b1;
    endcase
    if (brk_q && (seg inside {SEG_START, SEG_DATA, SEG_PAR, SEG_STOP})) level = 1'b0;
  end
endmodule

// File: rtl/sftx_pin.sv
`timescale 1ns/1ps
module sftx_pin (
  input  logic level,
  input  logic idle,
  input  logic cfg_invert,
  input  logic cfg_auto_tri,
  output logic tx_out,
  output logic tx_oe
);
  assign tx_out = level ^ cfg_invert;
  assign tx_oe  = !(idle && cfg_auto_tri);
endmodule

// File: rtl/sframe_tx.sv
`timescale 1ns/1ps
module sframe_tx
  import sftx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [3:0]      len_code,
  input  logic [1:0]      par_code,
  input  logic [1:0]      stop_code,
  input  logic [1:0]      ovs_code,
  input  logic            msb_first,
  input  logic            cfg_invert,
  input  logic            cfg_auto_tri,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DMAX-1:0] in_data,
  input  logic            in_break,
  output logic            tx_out,
  output logic            tx_oe,
  output logic            tx_done
);
  logic [DMAX-1:0] word;
  logic [NBW-1:0]  nbits;
  logic            par_en, par_val, level, idle, load, bit_step, brk_q;
  logic [TW-1:0]   olim, slim;

  assign olim     = ticks_per_bit(ovs_code);
  assign slim     = stop_span(stop_code, ovs_code);
  assign in_ready = idle;
  assign load     = in_valid && idle;

  sftx_shaper i_shaper (
    .in_data(in_data), .len_code(len_code), .par_code(par_code),
    .msb_first(msb_first), .word(word), .nbits(nbits),
    .par_en(par_en), .par_val(par_val)
  );

  sftx_seq i_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .ld_word(word), .ld_nbits(nbits), .ld_par_en(par_en), .ld_par_val(par_val),
    .ld_brk(in_break), .ld_olim(olim), .ld_slim(slim),
    .level(level), .idle(idle), .done(tx_done), .bit_step(bit_step), .brk_q(brk_q)
  );

  sftx_pin i_pin (
    .level(level), .idle(idle), .cfg_invert(cfg_invert),
    .cfg_auto_tri(cfg_auto_tri), .tx_out(tx_out), .tx_oe(tx_oe)
  );
endmodule

// File: rtl/sftx_checker.sv
`timescale 1ns/1ps
module sftx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_invert,
  input logic cfg_auto_tri,
  input logic tx_out,
  input logic tx_oe,
  input logic tx_done,
  input logic bit_step,
  input logic brk_q
);
  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_step |-> tick);
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tx_out == !cfg_invert));
  p_drive_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> tx_oe);
  p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && cfg_auto_tri) |-> !tx_oe);
  p_break_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && brk_q) |-> !in_ready);
  p_ready_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !brk_q) |-> in_ready);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

bind sframe_tx sftx_checker i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .cfg_invert(cfg_invert), .cfg_auto_tri(cfg_auto_tri),
  .tx_out(tx_out), .tx_oe(tx_oe), .tx_done(tx_done),
  .bit_step(bit_step), .brk_q(brk_q)
);

// File: tb/test_sframe_tx.sv
`timescale 1ns/1ps
module test_sframe_tx;
  logic        clk = 0, rst_n = 0, tick = 0;
  logic [3:0]  len_code = 4'd5;
  logic [1:0]  par_code = 0, stop_code = 1, ovs_code = 0;
  logic        msb_first = 0, cfg_invert = 0, cfg_auto_tri = 0;
  logic        in_valid = 0, in_break = 0;
  logic [15:0] in_data = 0;
  logic        in_ready, tx_out, tx_oe, tx_done;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  bit    exp_lvl[$];
  string exp_tag[$];
  int    exp_gap[$];

  always #2.5 clk = ~clk;

  sframe_tx i_sframe_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .len_code(len_code),
    .par_code(par_code), .stop_code(stop_code), .ovs_code(ovs_code),
    .msb_first(msb_first), .cfg_invert(cfg_invert), .cfg_auto_tri(cfg_auto_tri),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_break(in_break), .tx_out(tx_out), .tx_oe(tx_oe), .tx_done(tx_done)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic put(input bit v, input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) begin
      exp_lvl.push_back(v);
      exp_tag.push_back(tag);
    end
  endtask

  // Driver: offers a word, waits for it to be taken, then queues its expected tick levels.
  task automatic send(input logic [15:0] d, input bit brk, input logic [3:0] len,
                      input logic [1:0] par, input logic [1:0] stp, input logic [1:0] ovs,
                      input bit msb, input string tag);
    int o, n, ones, sp;
    bit pb;
    @(negedge clk);
    in_data = d; in_break = brk; len_code = len; par_code = par;
    stop_code = stp; ovs_code = ovs; msb_first = msb; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 0;
    o  = (ovs == 0) ? 16 : (ovs == 1) ? 8 : (ovs == 2) ? 6 : 4;
    n  = (len == 0) ? 4 : (len > 13) ? 16 : len + 3;
    sp = (stp == 0) ? o / 2 : (stp == 1) ? o : (stp == 2) ? o + o / 2 : 2 * o;
    ones = 0;
    put(1'b0, o, tag);
    for (int k = 0; k < n; k++) begin
      bit b;
      b = msb ? d[n - 1 - k] : d[k];
      ones += b;
      put(brk ? 1'b0 : b, o, tag);
    end
    if (par >= 2) begin
      pb = (ones % 2) == 1;
      if (par == 3) pb = !pb;
      put(brk ? 1'b0 : pb, o, tag);
    end
    put(!brk, sp, tag);
    if (brk) put(1'b1, o, tag);
    exp_gap.push_back(brk ? o : 0);
  endtask

  task automatic drain();
    while (exp_lvl.size() > 0 || !in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    bit lv; string tg; int g;
    if (rst_n) begin
      if (tick && exp_lvl.size() > 0) begin
        lv = exp_lvl.pop_front();
        tg = exp_tag.pop_front();
        check((tx_out ^ cfg_invert) == lv, tg, "line level", int'(tx_out ^ cfg_invert), int'(lv));
        check(tx_oe == 1'b1, "R8", "driver on during frame", int'(tx_oe), 1);
      end
      if (tx_done) begin
        if (exp_gap.size() == 0) check(1'b0, "R10", "unexpected done", 1, 0);
        else begin
          g = exp_gap.pop_front();
          check(exp_lvl.size() == g, "R10", "samples left at done", exp_lvl.size(), g);
        end
      end
    end
  end

  // Oversample strobe, one tick every third cycle
  initial begin
    int tc;
    tc = 0;
    forever begin
      @(posedge clk);
      #1 tick = (tc == 2);
      tc = (tc == 2) ? 0 : tc + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R10", "ready after reset", int'(in_ready), 1);
    check(tx_out == 1, "R7", "idle high after reset", int'(tx_out), 1);
    check(tx_oe == 1, "R8", "driven after reset", int'(tx_oe), 1);
    check(tx_done == 0, "R10", "no done after reset", int'(tx_done), 0);

    send(16'h00A5, 0, 4'd5, 2'd0, 2'd1, 2'd0, 0, "R2");
    @(negedge clk);
    check(in_ready == 0, "R10", "busy during frame", int'(in_ready), 0);
    send(16'h0037, 0, 4'd5, 2'd2, 2'd1, 2'd1, 0, "R4");
    send(16'h0037, 0, 4'd5, 2'd3, 2'd1, 2'd1, 0, "R4");
    send(16'h000B, 0, 4'd1, 2'd1, 2'd0, 2'd3, 0, "R5");
    send(16'hC3A1, 0, 4'd13, 2'd2, 2'd2, 2'd1, 1, "R6");
    send(16'h0155, 0, 4'd6, 2'd3, 2'd3, 2'd2, 1, "R6");
    send(16'h0FFF, 0, 4'd0, 2'd0, 2'd1, 2'd3, 0, "R1");
    send(16'h8001, 0, 4'd15, 2'd0, 2'd1, 2'd3, 0, "R1");
    send(16'h0021, 0, 4'd2, 2'd0, 2'd2, 2'd2, 0, "R3");
    send(16'h00FF, 1, 4'd5, 2'd2, 2'd3, 2'd3, 0, "R9");
    send(16'h0012, 0, 4'd5, 2'd0, 2'd1, 2'd3, 0, "R9");
    send(16'h005A, 0, 4'd5, 2'd2, 2'd3, 2'd0, 0, "R11");
    send(16'h0003, 0, 4'd1, 2'd0, 2'd0, 2'd3, 1, "R11");
    drain();

    cfg_invert = 1;
    @(negedge clk);
    check(tx_out == 0, "R7", "inverted idle", int'(tx_out), 0);
    send(16'h0069, 0, 4'd5, 2'd3, 2'd1, 2'd3, 0, "R7");
    drain();
    check(tx_out == 0, "R7", "inverted idle after frame", int'(tx_out), 0);
    cfg_invert = 0;

    cfg_auto_tri = 1;
    @(negedge clk);
    check(tx_oe == 0, "R8", "released while idle", int'(tx_oe), 0);
    send(16'h0044, 0, 4'd5, 2'd0, 2'd1, 2'd3, 0, "R8");
    drain();
    check(tx_oe == 0, "R8", "released after frame", int'(tx_oe), 0);
    cfg_auto_tri = 0;
    @(negedge clk);
    check(exp_gap.size() == 0, "R10", "done pulses outstanding", exp_gap.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule